// File: doc/BRIEF.md
# Two-Wire Byte Shift and Acknowledge Engine

This block moves one byte at a time over a two-wire serial bus. A host loads it, or reads it back, through a simple register port. Each byte takes eight data clocks. An optional ninth clock carries the acknowledge bit. When sending, the engine pulls SDA low for zero bits, starting with the most significant bit. When receiving, it samples SDA into the least significant bit and shifts left after each bit.

SCL is not generated here. A divider elsewhere supplies the line as a pair of one-cycle ticks, one for the rising edge and one for the falling edge. The engine changes SDA only after a falling tick and samples SDA only on a rising tick. An accepted host write does three things: it reloads the shift register, restarts the bit count and starts the transfer. In master mode it also raises a request for SCL to be driven.

Two configuration inputs set the acknowledge policy. One enables the ninth clock. The other chooses whether the receiving side pulls SDA low during that clock. The sending side releases SDA in the acknowledge slot and records the level it samples there.

Top module: `i2c_byte_engine`

## Requirements
- R1: With `dir_tx`=1, `sda_pull` during data bit k equals the inverse of bit 7-k of the written byte, so the most significant bit goes first. The register shifts left by one on each falling tick that follows a rising tick.
- R2: With `dir_tx`=0, each rising tick in a data bit shifts `rd_data` left by one and places `sda_in` in bit 0. After eight bits `rd_data` holds the received byte, with the first bit in bit 7.
- R3: A host write is accepted only while `eng_en`=1. A write with `eng_en`=0 leaves `rd_data`, `busy` and `scl_run` unchanged. `rd_data` is readable at all times.
- R4: An accepted write restarts the bit count at zero, even in the middle of a byte. The following eight data bits come from the newly written byte.
- R5: `scl_run` rises in the cycle after an accepted write only when `master_mode`=1. It falls when the transfer ends, and it is never high while `busy` is low.
- R6: With `ack_slot_en`=0, the transfer ends at the eighth falling tick and no ninth slot occurs. Later ticks change no output.
- R7: With `ack_slot_en`=1, a ninth slot follows the byte. When receiving, `sda_pull` is 1 in that slot if `ack_hold_high`=0 and 0 if `ack_hold_high`=1.
- R8: When sending, `sda_pull` is 0 in the acknowledge slot. `ack_seen` takes the value of `sda_in` at that slot's rising tick and keeps it until the next slot.
- R9: `done` is a single-cycle pulse in the cycle after the final falling tick, and `busy` is 0 in that same cycle.
- R10: While a transfer runs, `sda_pull` changes only in the cycle after a falling tick or an accepted write, provided the configuration inputs are held.
- R11: Driving `eng_en` to 0 during a transfer aborts it in the next cycle. `busy`, `scl_run` and `sda_pull` all go to 0, and `done` does not pulse.
- R12: After synchronous reset, `rd_data`=0, `sda_pull`=0, `scl_run`=0, `busy`=0, `done`=0 and `ack_seen`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eng_en | input | 1 | Engine enable; gates host writes and aborts when low |
| master_mode | input | 1 | 1 = request SCL when a transfer starts |
| dir_tx | input | 1 | 1 = this side sends the byte, 0 = receives |
| ack_slot_en | input | 1 | 1 = ninth acknowledge clock follows each byte |
| ack_hold_high | input | 1 | Receiver acknowledge level: 0 pulls low, 1 leaves high |
| wr_en | input | 1 | Host write strobe for the data register |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Shift register contents |
| scl_rise | input | 1 | One-cycle tick at an SCL rising edge |
| scl_fall | input | 1 | One-cycle tick at an SCL falling edge |
| sda_in | input | 1 | Sampled SDA line level |
| sda_pull | output | 1 | Open-drain pull-low enable for SDA |
| scl_run | output | 1 | Request to drive SCL for the current transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| ack_seen | output | 1 | SDA level sampled in the last acknowledge slot |

## Verification
The bench goes after the off-by-one at the end of a byte. A design that miscounts would end one clock early or late without the acknowledge slot, or, with the slot enabled, would skip it or shift in a ninth bit. Restarting in the middle of a byte is driven on purpose. A counter that is not cleared would send the tail of the new byte from the wrong position. Writes while disabled and aborts on disable are also exercised: a design that latched such a write would corrupt `rd_data`, and one that ignored the abort would keep pulling SDA low. The acknowledge slot is checked from both sides. It confirms that the receiver pulls low only for acknowledge level 0, that the sender releases the line, and that the sampled level is kept.

// File: rtl/i2c_eng_pkg.sv
// Shared definitions for the byte shift engine.
// Assumes a byte-oriented bus with one optional acknowledge slot.
package i2c_eng_pkg;
    localparam int BYTE_W = 8;

    // Which part of a byte transfer the engine is in.
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_DATA = 2'd1,
        SLOT_ACK  = 2'd2
    } slot_e;
endpackage

// File: rtl/i2c_eng_bitcnt.sv
// Bit position counter for one byte transfer.
// Counts completed data bits from 0 up to DATA_W and holds at DATA_W,
// which marks the acknowledge slot. A clear has priority over a step.
module i2c_eng_bitcnt #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last_data,
    output logic in_ack
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] ACK_IDX  = CNT_W'(DATA_W);

    logic [CNT_W-1:0] count;

    // Advance, restart or hold the bit position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (step && (count != ACK_IDX)) begin
            count <= count + 1'b1;
        end
    end

    // Decode the two positions the control logic needs.
    always_comb begin
        last_data = (count == LAST_IDX);
        in_ack    = (count == ACK_IDX);
    end

    // A restart must leave the counter at the first data bit.
    assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));

    // The counter never runs past the acknowledge slot.
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == ACK_IDX) && !clear |=> (count == ACK_IDX));
endmodule

// File: rtl/i2c_eng_shreg.sv
// Byte shift register shared by transmit and receive.
// A parallel load has priority. A receive shift pushes the serial input
// into the low end, and a transmit shift moves the word toward the high end.
// The two shift enables are assumed never to be high together.
module i2c_eng_shreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift_in_en,
    input  logic              sin,
    input  logic              shift_out_en,
    output logic [DATA_W-1:0] q
);
    // Load, shift in, shift out, or hold the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift_in_en) begin
            q <= {q[DATA_W-2:0], sin};
        end else if (shift_out_en) begin
            q <= {q[DATA_W-2:0], 1'b0};
        end
    end

    // A received bit lands in bit 0.
    assert_rx_lsb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_in_en && !load |=> (q[0] == $past(sin)));

    // A transmit shift promotes the next bit to the top.
    assert_tx_msb_R1: assert property (@(posedge clk) disable iff (!rst_n)
        shift_out_en && !load && !shift_in_en |=> (q[DATA_W-1] == $past(q[DATA_W-2])));
endmodule

// File: rtl/i2c_eng_ctrl.sv
// Transfer sequencer for the byte engine.
// Tracks whether a transfer runs, pairs each falling tick with the rising
// tick before it, ends the byte after the data bits or after the
// acknowledge slot, and records the acknowledge level.
// Assumes the rising and falling ticks are never high in the same cycle.
module i2c_eng_ctrl
    import i2c_eng_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eng_en,
    input  logic master_mode,
    input  logic ack_slot_en,
    input  logic wr_go,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic sda_in,
    input  logic last_data,
    input  logic in_ack,
    output logic busy,
    output logic scl_run,
    output logic done,
    output logic ack_seen,
    output logic rise_act,
    output logic step
);
    slot_e slot;
    logic  got_rise;
    logic  fall_act;
    logic  finish;

    // Work out the current slot and which ticks act in this cycle.
    always_comb begin
        if (!busy)       slot = SLOT_IDLE;
        else if (in_ack) slot = SLOT_ACK;
        else             slot = SLOT_DATA;
        rise_act = (slot != SLOT_IDLE) && eng_en && !wr_go && scl_rise;
        fall_act = (slot != SLOT_IDLE) && eng_en && !wr_go && scl_fall && got_rise;
        step     = fall_act && (slot == SLOT_DATA);
        finish   = fall_act && ((slot == SLOT_ACK) || (last_data && !ack_slot_en));
    end

    // Start, run, end or abort the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            scl_run  <= 1'b0;
            got_rise <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!eng_en) begin
                busy     <= 1'b0;
                scl_run  <= 1'b0;
                got_rise <= 1'b0;
            end else if (wr_go) begin
                busy     <= 1'b1;
                scl_run  <= master_mode;
                got_rise <= 1'b0;
            end else if (rise_act) begin
                got_rise <= 1'b1;
            end else if (fall_act) begin
                got_rise <= 1'b0;
                if (finish) begin
                    busy    <= 1'b0;
                    scl_run <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

    // Capture the line level at the rising tick of the acknowledge slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_seen <= 1'b1;
        end else if (rise_act && (slot == SLOT_ACK)) begin
            ack_seen <= sda_in;
        end
    end

    assert_ticks_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall}));

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_run_in_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        scl_run |-> busy);

    assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_en |=> !busy && !scl_run && !done);
endmodule

// File: rtl/i2c_byte_engine.sv
// Top of the byte shift and acknowledge engine.
// Joins the shift register, the bit counter and the sequencer, and forms
// the open-drain SDA pull-low enable. SCL is supplied as edge ticks, and
// the host port is a write strobe plus an always-valid read bus.
module i2c_byte_engine
    import i2c_eng_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eng_en,
    input  logic              master_mode,
    input  logic              dir_tx,
    input  logic              ack_slot_en,
    input  logic              ack_hold_high,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_in,
    output logic              sda_pull,
    output logic              scl_run,
    output logic              busy,
    output logic              done,
    output logic              ack_seen
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic wr_go;
    logic last_data;
    logic in_ack;
    logic rise_act;
    logic step;
    logic shift_in_en;
    logic shift_out_en;

    // Accept host writes only while enabled; choose the shift direction.
    always_comb begin
        wr_go        = wr_en && eng_en;
        shift_in_en  = rise_act && !dir_tx && !in_ack;
        shift_out_en = step && dir_tx;
    end

    i2c_eng_shreg #(.DATA_W(DATA_W)) u_shreg (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (wr_go),
        .load_val     (wr_data),
        .shift_in_en  (shift_in_en),
        .sin          (sda_in),
        .shift_out_en (shift_out_en),
        .q            (rd_data)
    );

    i2c_eng_bitcnt #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_bitcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (wr_go),
        .step      (step),
        .last_data (last_data),
        .in_ack    (in_ack)
    );

    i2c_eng_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .eng_en      (eng_en),
        .master_mode (master_mode),
        .ack_slot_en (ack_slot_en),
        .wr_go       (wr_go),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .sda_in      (sda_in),
        .last_data   (last_data),
        .in_ack      (in_ack),
        .busy        (busy),
        .scl_run     (scl_run),
        .done        (done),
        .ack_seen    (ack_seen),
        .rise_act    (rise_act),
        .step        (step)
    );

    // Open-drain SDA: sender drives data bits, receiver drives acknowledge.
    always_comb begin
        sda_pull = 1'b0;
        if (busy) begin
            if (in_ack) sda_pull = !dir_tx && !ack_hold_high;
            else        sda_pull = dir_tx && !rd_data[DATA_W-1];
        end
    end

    assert_write_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && eng_en |=> busy && (rd_data == $past(wr_data)));

    assert_disabled_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !eng_en |=> $stable(rd_data) && !busy);

    assert_sda_after_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && !$past(scl_fall) && !$past(wr_en)
            && $stable(dir_tx) && $stable(ack_hold_high) |-> $stable(sda_pull));

    assert_tx_releases_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && in_ack && dir_tx |-> !sda_pull);
endmodule

// File: tb/i2c_byte_engine_tb.sv
module i2c_byte_engine_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       eng_en = 1'b0, master_mode = 1'b0, dir_tx = 1'b0;
    logic       ack_slot_en = 1'b0, ack_hold_high = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       scl_rise = 1'b0, scl_fall = 1'b0, sda_in = 1'b1;
    logic       sda_pull, scl_run, busy, done, ack_seen;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R12";
    bit    finished = 1'b0;

    // Behavioural reference state
    logic [7:0] m_data = 8'h00;
    int         m_cnt = 0;
    bit         m_busy = 0, m_run = 0, m_gr = 0, m_done = 0, m_ack = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_byte_engine u_dut (
        .clk(clk), .rst_n(rst_n), .eng_en(eng_en), .master_mode(master_mode),
        .dir_tx(dir_tx), .ack_slot_en(ack_slot_en), .ack_hold_high(ack_hold_high),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
        .sda_pull(sda_pull), .scl_run(scl_run), .busy(busy), .done(done),
        .ack_seen(ack_seen)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model update on every clock, then compare away from the edge.
    always @(posedge clk) begin
        bit exp_pull;
        if (!rst_n) begin
            m_data = 8'h00; m_cnt = 0; m_busy = 0; m_run = 0; m_gr = 0; m_done = 0; m_ack = 1;
        end else begin
            m_done = 0;
            if (!eng_en) begin
                m_busy = 0; m_run = 0; m_gr = 0;
            end else if (wr_en) begin
                m_data = wr_data; m_cnt = 0; m_busy = 1; m_run = master_mode; m_gr = 0;
            end else if (m_busy) begin
                if (scl_rise) begin
                    m_gr = 1;
                    if (m_cnt < 8 && !dir_tx) m_data = {m_data[6:0], sda_in};
                    if (m_cnt == 8) m_ack = sda_in;
                end else if (scl_fall && m_gr) begin
                    m_gr = 0;
                    if (m_cnt == 8 || (m_cnt == 7 && !ack_slot_en)) begin
                        m_busy = 0; m_run = 0; m_done = 1;
                    end
                    if (m_cnt < 8) begin
                        if (dir_tx) m_data = m_data << 1;
                        m_cnt++;
                    end
                end
            end
        end
        #(CLK_PERIOD/4);
        if (!finished) begin
            if (m_busy) exp_pull = (m_cnt == 8) ? (!dir_tx && !ack_hold_high)
                                                : (dir_tx && !m_data[7]);
            else        exp_pull = 0;
            chk(cur_req, "cycle rd_data", rd_data, m_data);
            chk(cur_req, "cycle sda_pull R10", sda_pull, exp_pull);
            chk(cur_req, "cycle busy/run/done/ack", {busy, scl_run, done, ack_seen},
                {m_busy, m_run, m_done, m_ack});
        end
    end

    task automatic host_write(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // One SCL period: rising tick, gap, falling tick, gap.
    task automatic scl_bit(input logic b, output logic seen);
        @(negedge clk); sda_in = b; seen = !sda_pull; scl_rise = 1'b1;
        @(negedge clk); scl_rise = 1'b0;
        @(negedge clk); scl_fall = 1'b1;
        @(negedge clk); scl_fall = 1'b0;
    endtask

    task automatic run_bits(input logic [7:0] bits, input int n, output logic [7:0] seen);
        seen = 8'h00;
        for (int i = 0; i < n; i++) begin
            logic s;
            scl_bit(bits[7-i], s);
            seen[7-i] = s;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] seen;
        logic       s;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12", "rd_data", rd_data, 0);
        chk("R12", "sda_pull", sda_pull, 0);
        chk("R12", "busy/run/done", {busy, scl_run, done}, 0);
        chk("R12", "ack_seen", ack_seen, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R5 R8: master transmit, slave acknowledges low
        cur_req = "R1"; eng_en = 1; master_mode = 1; dir_tx = 1; ack_slot_en = 1; ack_hold_high = 1;
        host_write(8'hA5);
        chk("R5", "scl_run after master write", scl_run, 1);
        run_bits(8'hFF, 8, seen);
        chk("R1", "serial bits", seen, 8'hA5);
        cur_req = "R8";
        scl_bit(1'b0, s);
        chk("R8", "sender released ack slot", s, 1);
        chk("R9", "done pulse", done, 1);
        chk("R8", "ack_seen low", ack_seen, 0);
        chk("R5", "scl_run dropped", scl_run, 0);

        // R2 R7: slave receive, acknowledge pulled low
        cur_req = "R2"; master_mode = 0; dir_tx = 0; ack_hold_high = 0;
        host_write(8'h00);
        chk("R5", "no scl_run in slave mode", scl_run, 0);
        run_bits(8'h3C, 8, seen);
        chk("R2", "received byte", rd_data, 8'h3C);
        cur_req = "R7";
        scl_bit(1'b1, s);
        chk("R7", "receiver pulled ack low", s, 0);
        chk("R9", "done after ack", done, 1);

        // R7: receive with acknowledge left high
        ack_hold_high = 1;
        host_write(8'h00);
        run_bits(8'hC3, 8, seen);
        chk("R2", "received byte 2", rd_data, 8'hC3);
        scl_bit(1'b1, s);
        chk("R7", "receiver left ack high", s, 1);

        // R6: no acknowledge slot
        cur_req = "R6"; dir_tx = 1; master_mode = 1; ack_slot_en = 0;
        host_write(8'h81);
        run_bits(8'hFF, 7, seen);
        chk("R6", "busy before last fall", busy, 1);
        run_bits(8'hFF, 1, seen);
        chk("R6", "done after 8th bit", done, 1);
        chk("R6", "idle after 8th bit", busy, 0);
        scl_bit(1'b0, s);
        chk("R6", "extra clock ignored", {busy, sda_pull, done}, 0);

        // R3: write while disabled is ignored
        cur_req = "R3"; eng_en = 0;
        host_write(8'h5A);
        chk("R3", "disabled write rd_data", rd_data, 8'h00);
        chk("R3", "disabled write busy/run", {busy, scl_run}, 0);
        eng_en = 1;
        @(negedge clk);

        // R4: restart in the middle of a byte
        cur_req = "R4";
        host_write(8'hF0);
        run_bits(8'hFF, 3, seen);
        host_write(8'h0F);
        run_bits(8'hFF, 8, seen);
        chk("R4", "restarted byte bits", seen, 8'h0F);
        chk("R4", "done after restarted byte", done, 1);

        // R11: abort by disabling during a transfer
        cur_req = "R11";
        host_write(8'h00);
        run_bits(8'hFF, 2, seen);
        chk("R11", "pulling before abort", sda_pull, 1);
        @(negedge clk); eng_en = 0;
        @(negedge clk);
        chk("R11", "aborted outputs", {busy, scl_run, sda_pull, done}, 0);
        eng_en = 1;

        // R8: transmit with acknowledge not given
        cur_req = "R8"; ack_slot_en = 1;
        host_write(8'h6E);
        run_bits(8'hFF, 8, seen);
        chk("R1", "serial bits 2", seen, 8'h6E);
        scl_bit(1'b1, s);
        chk("R8", "ack_seen high", ack_seen, 1);
        @(negedge clk);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule